// File: doc/BRIEF.md
# Keyboard Controller Host Port

This block is the processor-facing side of a keyboard controller. The host sees two byte-wide ports: a data port and a command/status port. A host write to either port fills a one-byte input buffer, and the block records which port was used so that the command engine can tell a command from a data byte. The command engine itself is a separate block. It sees the pending byte and its type, consumes it with a take pulse, and can rewrite the configuration byte that gates interrupts and drives two status bits.

Bytes arriving from the serial device side carry a source tag (keyboard or auxiliary/mouse) and two error flags (parity and timeout). They are loaded into a one-byte output buffer only while that buffer is empty. Otherwise the device side is told to stall. Reading the data port hands the byte to the host and frees the buffer. Reading the command/status port returns an 8-bit status word and changes nothing. Two interrupt request lines follow the output buffer: one for keyboard bytes and one for auxiliary bytes, each enabled by its own configuration bit.

Top module: `kbc_host_port`

## Requirements
- R1: After reset the output buffer and input buffer are empty, the error, source and command flags are 0, the configuration byte equals the CFG_RST parameter (default 0x00), and both interrupt lines are low.
- R2: A host write (host_cs=1, host_we=1) to CMD_PORT (default 0x64) or DATA_PORT (default 0x60) loads host_wdata into the input buffer from the next cycle. It sets ctl_ib_valid and status bit 1. It sets ctl_ib_is_cmd and status bit 3 to 1 for CMD_PORT and to 0 for DATA_PORT.
- R3: A ctl_ib_take pulse clears ctl_ib_valid and status bit 1 from the next cycle. If a host write arrives in the same cycle, the write wins: the buffer stays full and holds the new byte.
- R4: When dev_valid=1 and the output buffer is empty, dev_byte is loaded and status bit 0 is set from the next cycle. Status bit 5 takes dev_aux (1 = auxiliary), bit 7 takes dev_par_err and bit 6 takes dev_timeout. Both error bits may be 1 together. Bits 7..5 hold until the next load.
- R5: dev_stall equals the output-buffer-full flag. A dev_valid while the buffer is full has no effect on the buffered byte or its flags.
- R6: A host read (host_cs=1, host_we=0) of DATA_PORT returns the buffered byte on host_rdata in the same cycle. It clears status bit 0 from the next cycle. A read of DATA_PORT while the buffer is empty changes nothing.
- R7: A host read of CMD_PORT returns the status word {parity, timeout, aux, unlocked, last-was-command, system, input-full, output-full} (bit 7 down to bit 0) and changes no state.
- R8: irq_kbd is high exactly while the output buffer holds a keyboard byte and configuration bit 0 is 1. irq_aux is high exactly while it holds an auxiliary byte and configuration bit 1 is 1. Both drop once the data-port read has emptied the buffer.
- R9: Status bit 2 equals configuration bit 2. Status bit 4 equals kbd_unlocked OR configuration bit 3.
- R10: A ctl_cfg_wr pulse loads ctl_cfg_data into the configuration byte (ctl_cfg_q) from the next cycle, with bit 7 always stored as 0.
- R11: An access to any address other than the two ports changes no state, and host_rdata is 0x00 whenever the cycle is not a read of one of the two ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host port address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| ctl_ib_valid | output | 1 | Input buffer holds an unconsumed byte |
| ctl_ib_data | output | 8 | Input buffer byte |
| ctl_ib_is_cmd | output | 1 | Last host write went to the command port |
| ctl_ib_take | input | 1 | Command engine consumes the input byte |
| ctl_cfg_wr | input | 1 | Configuration byte write strobe |
| ctl_cfg_data | input | 8 | New configuration byte |
| ctl_cfg_q | output | 8 | Current configuration byte |
| kbd_unlocked | input | 1 | Keyboard lock input, 1 = not locked |
| dev_valid | input | 1 | Device byte offered |
| dev_byte | input | 8 | Device byte |
| dev_aux | input | 1 | Byte source, 1 = auxiliary |
| dev_par_err | input | 1 | Parity error on the byte |
| dev_timeout | input | 1 | Timeout on the byte |
| dev_stall | output | 1 | Output buffer full, device must hold |
| irq_kbd | output | 1 | Keyboard interrupt request |
| irq_aux | output | 1 | Auxiliary interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, data port 0x60, command port 0x64 and a reset configuration byte of 0x00. With the full 8-bit decode, near-miss addresses such as 0x61 and 0xE4 can be used to show that only the two exact ports act. With the zero reset value, the system flag and interrupt enables start cleared, so each of them is seen to switch only through a configuration write. Directed sequences cover the write-versus-take race, loading while full and both-error bytes. A stretch of random traffic then runs against the reference model on every clock.

// File: rtl/kbc_host_pkg.sv
package kbc_host_pkg;

    // Status word; bit order is the host-visible register layout.
    typedef struct packed {
        logic par_err;
        logic timeout;
        logic aux_src;
        logic unlocked;
        logic last_cmd;
        logic sys_flag;
        logic ib_full;
        logic ob_full;
    } kbc_status_t;

    typedef enum logic [1:0] {
        HP_NONE = 2'd0,
        HP_DATA = 2'd1,
        HP_CMD  = 2'd2
    } hport_e;

    typedef struct packed {
        logic   wr;
        logic   rd;
        hport_e port;
    } host_acc_t;

    typedef struct packed {
        logic [7:0] val;
        logic       aux;
        logic       par;
        logic       tmo;
    } dev_word_t;

    localparam int CFG_KBD_IRQ = 0;
    localparam int CFG_AUX_IRQ = 1;
    localparam int CFG_SYS     = 2;
    localparam int CFG_NOLOCK  = 3;

    function automatic logic [7:0] cfg_clean(input logic [7:0] v);
        return {1'b0, v[6:0]};
    endfunction

endpackage

// File: rtl/kbc_host_decode.sv
module kbc_host_decode
    import kbc_host_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output host_acc_t         acc
);
    always_comb begin
        acc = '{wr: 1'b0, rd: 1'b0, port: HP_NONE};
        if (cs) begin
            if (addr == DATA_PORT)     acc.port = HP_DATA;
            else if (addr == CMD_PORT) acc.port = HP_CMD;
            if (acc.port != HP_NONE) begin
                acc.wr = we;
                acc.rd = !we;
            end
        end
    end
endmodule

// File: rtl/kbc_in_buf.sv
module kbc_in_buf
    import kbc_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_acc_t  acc,
    input  logic [7:0] wdata,
    input  logic       take,
    output logic       full,
    output logic       is_cmd,
    output logic [7:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            is_cmd <= 1'b0;
            data   <= 8'h00;
        end else if (acc.wr) begin
            full   <= 1'b1;
            is_cmd <= (acc.port == HP_CMD);
            data   <= wdata;
        end else if (take) begin
            full   <= 1'b0;
        end
    end

    assert_write_fills_R2: assert property (@(posedge clk) disable iff (rst)
        acc.wr |=> full && data == $past(wdata) && is_cmd == ($past(acc.port) == HP_CMD));

    assert_take_empties_R3: assert property (@(posedge clk) disable iff (rst)
        take && !acc.wr |=> !full);
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_host_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dev_valid,
    input  dev_word_t dev_in,
    input  logic      pop,
    output logic      full,
    output dev_word_t word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (pop && full) begin
            full <= 1'b0;
        end else if (dev_valid && !full) begin
            full <= 1'b1;
            word <= dev_in;
        end
    end

    assert_load_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
        dev_valid && !full |=> full && word == $past(dev_in));

    assert_no_load_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(word));

    assert_pop_empties_R6: assert property (@(posedge clk) disable iff (rst)
        pop && full |=> !full);
endmodule

// File: rtl/kbc_cfg_reg.sv
module kbc_cfg_reg
    import kbc_host_pkg::*;
#(
    parameter logic [7:0] CFG_RST = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= cfg_clean(CFG_RST);
        else if (wr) q <= cfg_clean(wdata);
    end

    assert_cfg_top_bit_zero_R10: assert property (@(posedge clk) disable iff (rst)
        wr |=> !q[7] && q[6:0] == $past(wdata[6:0]));
endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port
    import kbc_host_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64,
    parameter logic [7:0] CFG_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              ctl_ib_valid,
    output logic [7:0]        ctl_ib_data,
    output logic              ctl_ib_is_cmd,
    input  logic              ctl_ib_take,
    input  logic              ctl_cfg_wr,
    input  logic [7:0]        ctl_cfg_data,
    output logic [7:0]        ctl_cfg_q,
    input  logic              kbd_unlocked,
    input  logic              dev_valid,
    input  logic [7:0]        dev_byte,
    input  logic              dev_aux,
    input  logic              dev_par_err,
    input  logic              dev_timeout,
    output logic              dev_stall,
    output logic              irq_kbd,
    output logic              irq_aux
);
    host_acc_t   acc;
    dev_word_t   dev_in;
    dev_word_t   ob_word;
    logic        ob_full;
    logic        host_pop;
    kbc_status_t status;

    kbc_host_decode #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)) u_dec (
        .cs(host_cs), .we(host_we), .addr(host_addr), .acc(acc)
    );

    kbc_in_buf u_ib (
        .clk(clk), .rst(rst), .acc(acc), .wdata(host_wdata), .take(ctl_ib_take),
        .full(ctl_ib_valid), .is_cmd(ctl_ib_is_cmd), .data(ctl_ib_data)
    );

    assign dev_in   = '{val: dev_byte, aux: dev_aux, par: dev_par_err, tmo: dev_timeout};
    assign host_pop = acc.rd && (acc.port == HP_DATA);

    kbc_out_buf u_ob (
        .clk(clk), .rst(rst), .dev_valid(dev_valid), .dev_in(dev_in), .pop(host_pop),
        .full(ob_full), .word(ob_word)
    );

    kbc_cfg_reg #(.CFG_RST(CFG_RST)) u_cfg (
        .clk(clk), .rst(rst), .wr(ctl_cfg_wr), .wdata(ctl_cfg_data), .q(ctl_cfg_q)
    );

    always_comb begin
        status.par_err  = ob_word.par;
        status.timeout  = ob_word.tmo;
        status.aux_src  = ob_word.aux;
        status.unlocked = kbd_unlocked | ctl_cfg_q[CFG_NOLOCK];
        status.last_cmd = ctl_ib_is_cmd;
        status.sys_flag = ctl_cfg_q[CFG_SYS];
        status.ib_full  = ctl_ib_valid;
        status.ob_full  = ob_full;
    end

    always_comb begin
        host_rdata = 8'h00;
        if (acc.rd) begin
            if (acc.port == HP_DATA)     host_rdata = ob_word.val;
            else if (acc.port == HP_CMD) host_rdata = status;
        end
    end

    assign dev_stall = ob_full;
    assign irq_kbd   = ob_full && !ob_word.aux && ctl_cfg_q[CFG_KBD_IRQ];
    assign irq_aux   = ob_full &&  ob_word.aux && ctl_cfg_q[CFG_AUX_IRQ];

    assert_irq_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(irq_kbd && irq_aux));

    assert_irq_drops_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        host_pop && ob_full |=> !irq_kbd && !irq_aux);

    assert_status_read_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
        acc.rd && acc.port == HP_CMD && !ctl_ib_take && !dev_valid && !ctl_cfg_wr
        |=> $stable(ob_full) && $stable(ctl_ib_valid) && $stable(ctl_cfg_q));

    assert_stray_addr_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        host_cs && host_we && acc.port == HP_NONE && !ctl_ib_take |=> $stable(ctl_ib_valid) && $stable(ctl_ib_data));
endmodule

// File: tb/sim_kbc_host_port.sv
module sim_kbc_host_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_cs, host_we;
    logic [7:0] host_addr, host_wdata, host_rdata;
    logic       ctl_ib_valid, ctl_ib_is_cmd, ctl_ib_take;
    logic [7:0] ctl_ib_data;
    logic       ctl_cfg_wr;
    logic [7:0] ctl_cfg_data, ctl_cfg_q;
    logic       kbd_unlocked;
    logic       dev_valid, dev_aux, dev_par_err, dev_timeout, dev_stall;
    logic [7:0] dev_byte;
    logic       irq_kbd, irq_aux;

    always #10 clk = ~clk;

    kbc_host_port u0 (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ctl_ib_valid(ctl_ib_valid),
        .ctl_ib_data(ctl_ib_data), .ctl_ib_is_cmd(ctl_ib_is_cmd), .ctl_ib_take(ctl_ib_take),
        .ctl_cfg_wr(ctl_cfg_wr), .ctl_cfg_data(ctl_cfg_data), .ctl_cfg_q(ctl_cfg_q),
        .kbd_unlocked(kbd_unlocked), .dev_valid(dev_valid), .dev_byte(dev_byte),
        .dev_aux(dev_aux), .dev_par_err(dev_par_err), .dev_timeout(dev_timeout),
        .dev_stall(dev_stall), .irq_kbd(irq_kbd), .irq_aux(irq_aux)
    );

    // reference model state
    bit       m_ibf, m_cmd, m_obf, m_aux, m_par, m_tmo;
    bit [7:0] m_ib, m_ob, m_cfg;
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        host_cs = 0; host_we = 0; host_addr = 8'h00; host_wdata = 8'h00;
        ctl_ib_take = 0; ctl_cfg_wr = 0; ctl_cfg_data = 8'h00;
        dev_valid = 0; dev_byte = 8'h00; dev_aux = 0; dev_par_err = 0; dev_timeout = 0;
    endtask

    function automatic bit [7:0] m_status();
        return {m_par, m_tmo, m_aux, kbd_unlocked | m_cfg[3], m_cmd, m_cfg[2], m_ibf, m_obf};
    endfunction

    // Inputs are already set (after a negedge); compare, then advance one clock.
    task automatic step(string tag);
        bit [7:0] exp_rd;
        bit is_data, is_cmd;
        is_data = host_cs && host_addr == 8'h60;
        is_cmd  = host_cs && host_addr == 8'h64;
        #1;
        exp_rd = 8'h00;
        if (!host_we && is_data) exp_rd = m_ob;
        if (!host_we && is_cmd)  exp_rd = m_status();
        chk(tag, "host_rdata", host_rdata, exp_rd);
        chk(tag, "dev_stall", dev_stall, m_obf);
        chk(tag, "irq_kbd", irq_kbd, m_obf && !m_aux && m_cfg[0]);
        chk(tag, "irq_aux", irq_aux, m_obf && m_aux && m_cfg[1]);
        chk(tag, "ctl_ib_valid", ctl_ib_valid, m_ibf);
        chk(tag, "ctl_ib_data", ctl_ib_data, m_ib);
        chk(tag, "ctl_ib_is_cmd", ctl_ib_is_cmd, m_cmd);
        chk(tag, "ctl_cfg_q", ctl_cfg_q, m_cfg);
        @(posedge clk);
        if (host_we && (is_data || is_cmd)) begin
            m_ibf = 1; m_ib = host_wdata; m_cmd = is_cmd;
        end else if (ctl_ib_take) m_ibf = 0;
        if (!host_we && is_data && m_obf) m_obf = 0;
        else if (dev_valid && !m_obf) begin
            m_obf = 1; m_ob = dev_byte; m_aux = dev_aux; m_par = dev_par_err; m_tmo = dev_timeout;
        end
        if (ctl_cfg_wr) m_cfg = ctl_cfg_data & 8'h7f;
        @(negedge clk);
        idle();
    endtask

    task automatic hw(bit [7:0] a, bit [7:0] d, string tag);
        host_cs = 1; host_we = 1; host_addr = a; host_wdata = d; step(tag);
    endtask
    task automatic hr(bit [7:0] a, string tag);
        host_cs = 1; host_we = 0; host_addr = a; step(tag);
    endtask
    task automatic dv(bit [7:0] b, bit aux, bit par, bit tmo, string tag);
        dev_valid = 1; dev_byte = b; dev_aux = aux; dev_par_err = par; dev_timeout = tmo; step(tag);
    endtask
    task automatic cw(bit [7:0] d, string tag);
        ctl_cfg_wr = 1; ctl_cfg_data = d; step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(); kbd_unlocked = 0; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_ibf = 0; m_cmd = 0; m_obf = 0; m_aux = 0; m_par = 0; m_tmo = 0;
        m_ib = 0; m_ob = 0; m_cfg = 8'h00;

        // R1 reset state via status read
        host_cs = 1; host_we = 0; host_addr = 8'h64; #1;
        chk("R1", "reset status", host_rdata, 8'h00);
        step("R1");
        kbd_unlocked = 1;
        hr(8'h64, "R9 unlocked input");

        // R2 / R3 input buffer
        hw(8'h64, 8'hAA, "R2 cmd write");
        hr(8'h64, "R2 status after cmd");
        ctl_ib_take = 1; step("R3 take");
        hw(8'h60, 8'h55, "R2 data write");
        host_cs = 1; host_we = 1; host_addr = 8'h64; host_wdata = 8'h20; ctl_ib_take = 1;
        step("R3 take with write");
        hr(8'h64, "R3 write won");
        ctl_ib_take = 1; step("R3 take");

        // R9 / R10 configuration
        kbd_unlocked = 0;
        cw(8'h8D, "R10 cfg bit7 dropped");
        hr(8'h64, "R9 sys and nolock");

        // R4 / R5 / R6 / R8 keyboard byte
        dv(8'h1C, 0, 0, 0, "R4 kbd load");
        dv(8'h33, 1, 1, 1, "R5 load while full");
        hr(8'h64, "R7 status read");
        hr(8'h64, "R7 status read again");
        hr(8'h60, "R6 data read");
        hr(8'h64, "R8 irq dropped");
        hr(8'h60, "R6 read when empty");

        // R4 / R8 aux byte with both errors
        dv(8'hF0, 1, 1, 1, "R4 aux load both errors");
        hr(8'h64, "R4 status bits 7..5");
        cw(8'h02, "R8 aux irq enable");
        step("R8 aux irq high");
        hr(8'h60, "R6 aux read");
        hr(8'h64, "R4 flags held after read");

        // R11 stray addresses
        hw(8'h61, 8'h77, "R11 stray write");
        hw(8'hE4, 8'h77, "R11 stray write");
        hr(8'h61, "R11 stray read");
        dv(8'h42, 0, 0, 0, "R11 prep");
        hr(8'hE0, "R11 stray read keeps buffer");
        hr(8'h60, "R11 byte still there");

        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            kbd_unlocked = $urandom_range(0, 1);
            host_cs = sel < 6;
            host_we = $urandom_range(0, 1);
            case ($urandom_range(0, 4))
                0, 1: host_addr = 8'h60;
                2, 3: host_addr = 8'h64;
                default: host_addr = 8'h65;
            endcase
            host_wdata = 8'($urandom);
            ctl_ib_take = $urandom_range(0, 2) == 0;
            ctl_cfg_wr = $urandom_range(0, 7) == 0;
            ctl_cfg_data = 8'($urandom);
            dev_valid = $urandom_range(0, 1);
            dev_byte = 8'($urandom);
            dev_aux = $urandom_range(0, 1);
            dev_par_err = $urandom_range(0, 1);
            dev_timeout = $urandom_range(0, 1);
            step("R2 R4 R6 R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule